// File: doc/BRIEF.md
# Ring-Buffered Stack-Top Cache

This block keeps the uppermost entries of an operand stack in a small ring of registers. The rest of the stack lives in an external memory, which grows downward. A client issues one command at a time over a valid/ready handshake. The commands are: push an immediate, add the two uppermost entries, pop the uppermost entry to an output, and flush.

The ring is tracked by only two values. One is a wrap-around index of the register that holds the stack top. The other is a count of how many stack entries are currently held in registers.

- When a push finds the ring full, the block first writes the entry it is about to overwrite out to memory.
- When an add or a pop finds too few entries in the ring, the block reads the missing ones back from memory.
- A flush writes every cached entry to memory, deepest first, and leaves the ring empty. This gives a known state at points where control flow merges.

The memory port carries one access per cycle. Reads are combinational: `mem_rdata` must reflect `mem_addr` in the same cycle. A write takes effect at the clock edge that ends the cycle in which it is requested.

Top module: `stk_top_cache`

## Requirements
- R1: After reset the ring is empty, `cmd_ready` is 1, and `mem_req` and `pop_valid` are 0. The memory stack pointer equals `SP_RESET`, so the first value written to memory goes to address `SP_RESET-1`.
- R2: A command is taken when `cmd_valid` and `cmd_ready` are both 1. The command encoding is `cmd_op`: 0 = push, 1 = add, 2 = pop, 3 = flush. `cmd_ready` then stays 0 for exactly as many cycles as the command has steps. Each step is one cycle and makes at most one memory access.
- R3: A push into a ring that is not full takes one step and makes no memory access.
- R4: A push into a full ring (`SLOT_HI-SLOT_LO+1` entries) takes one step. In that step it writes the oldest cached entry to address `sp-1` and decrements `sp`. The ring count stays at its maximum.
- R5: A pop with at least one cached entry takes one step. In that step `pop_valid` is 1 and `pop_data` is the stack top. Values come out in last-in, first-out order.
- R6: A pop with an empty ring first reads address `sp` and increments `sp`. It then delivers that value in a second step.
- R7: An add with two or more cached entries takes one step and makes no memory access. It replaces the two uppermost entries with their sum modulo 2^DW.
- R8: An add with one cached entry does one memory read before summing. An add with an empty ring does two memory reads, at `sp` and then `sp+1`, before summing. This gives 2 and 3 steps respectively.
- R9: A flush of a ring holding n > 0 entries takes n steps. Each step writes one entry, deepest first, to descending addresses. Afterwards the logical stack entry at depth i from the bottom is at address `SP_RESET-1-i`, and the ring is empty.
- R10: A flush of an empty ring takes one step and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | Command code (0 push, 1 add, 2 pop, 3 flush) |
| cmd_imm | input | DW | Immediate value for push |
| pop_valid | output | 1 | Popped value present this cycle |
| pop_data | output | DW | Popped value |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data for `mem_addr`, same cycle |

## Verification
The hardest situations to reach from the ports are those where the ring has wrapped several times and its occupancy is at an edge when a command arrives. Examples are an add with an empty or single-entry ring that follows a spill, and a flush whose oldest entry sits across the wrap from the top. Only long, mixed command streams produce these.

The bench therefore runs a long pseudo-random stream of pushes, adds, pops and flushes. It keeps the stack depth between zero and a few dozen entries. It mirrors the ring occupancy arithmetically to predict, for every command, the step count, the memory traffic and each address. After every flush it compares the whole memory image with its own record of the stack.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    OP_PUSH  = 2'd0,
    OP_ADD   = 2'd1,
    OP_POP   = 2'd2,
    OP_FLUSH = 2'd3
  } stk_op_e;

  // slot above s on the ring
  function automatic int ring_fwd(int s, int lo, int hi);
    return (s == hi) ? lo : s + 1;
  endfunction

  // slot below s on the ring
  function automatic int ring_bwd(int s, int lo, int hi);
    return (s == lo) ? hi : s - 1;
  endfunction

  // slot holding the deepest of n cached entries when s is the top
  function automatic int ring_deepest(int s, int n, int lo, int hi);
    int idx;
    idx = (n == 0) ? s : s - (n - 1);
    if (idx < lo) idx = idx + (hi - lo + 1);
    return idx;
  endfunction

endpackage

// File: rtl/stk_regring.sv
module stk_regring #(
  parameter int DW      = 16,
  parameter int SLOT_LO = 3,
  parameter int SLOT_HI = 12,
  parameter int SW      = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_slot,
  input  logic [DW-1:0] wr_data,
  input  logic [SW-1:0] rd_slot_a,
  input  logic [SW-1:0] rd_slot_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b
);

  logic [DW-1:0] slot_q [SLOT_LO:SLOT_HI];

  for (genvar g = SLOT_LO; g <= SLOT_HI; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wr_slot == SW'(g)) slot_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data_a = '0;
    rd_data_b = '0;
    for (int i = SLOT_LO; i <= SLOT_HI; i++) begin
      if (rd_slot_a == SW'(i)) rd_data_a = slot_q[i];
      if (rd_slot_b == SW'(i)) rd_data_b = slot_q[i];
    end
  end

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 8,
  parameter int SLOT_LO  = 3,
  parameter int SLOT_HI  = 12,
  parameter int SW       = 4,
  parameter int SP_RESET = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_imm,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rf_we,
  output logic [SW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic [SW-1:0] rf_ra,
  output logic [SW-1:0] rf_rb,
  input  logic [DW-1:0] rf_rd_a,
  input  logic [DW-1:0] rf_rd_b
);

  localparam int SIZE = SLOT_HI - SLOT_LO + 1;
  localparam int CW   = $clog2(SIZE + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(SIZE);

  function automatic logic [DW-1:0] sum_wrap(logic [DW-1:0] x, logic [DW-1:0] y);
    return x + y;
  endfunction

  logic          busy_q;
  stk_op_e       op_q;
  logic [DW-1:0] imm_q;
  logic [SW-1:0] top_q, top_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] sp_q, sp_d;

  // named internal events
  logic accept_ev, last_ev, spill_ev, fill_ev, ring_full;
  logic [SW-1:0] slot_up, slot_dn, slot_old;

  assign cmd_ready = !busy_q;
  assign accept_ev = cmd_valid && cmd_ready;
  assign ring_full = (cnt_q == CNT_FULL);
  assign slot_up   = SW'(ring_fwd(int'(top_q), SLOT_LO, SLOT_HI));
  assign slot_dn   = SW'(ring_bwd(int'(top_q), SLOT_LO, SLOT_HI));
  assign slot_old  = SW'(ring_deepest(int'(top_q), int'(cnt_q), SLOT_LO, SLOT_HI));
  assign rf_rb     = slot_dn;
  assign pop_data  = rf_rd_a;

  always_comb begin
    last_ev   = 1'b0;
    spill_ev  = 1'b0;
    fill_ev   = 1'b0;
    pop_valid = 1'b0;
    rf_we     = 1'b0;
    rf_waddr  = top_q;
    rf_wdata  = imm_q;
    rf_ra     = top_q;
    top_d     = top_q;
    cnt_d     = cnt_q;
    sp_d      = sp_q;
    if (busy_q) begin
      unique case (op_q)
        OP_PUSH: begin
          rf_ra    = slot_up;
          spill_ev = ring_full;
          rf_we    = 1'b1;
          rf_waddr = slot_up;
          top_d    = slot_up;
          if (!ring_full) cnt_d = cnt_q + CW'(1);
          last_ev  = 1'b1;
        end
        OP_ADD: begin
          if (cnt_q == '0) begin
            fill_ev  = 1'b1;
            rf_we    = 1'b1;
            rf_waddr = top_q;
            rf_wdata = mem_rdata;
            cnt_d    = CW'(1);
          end else if (cnt_q == CW'(1)) begin
            fill_ev  = 1'b1;
            rf_we    = 1'b1;
            rf_waddr = slot_dn;
            rf_wdata = mem_rdata;
            cnt_d    = CW'(2);
          end else begin
            rf_we    = 1'b1;
            rf_waddr = slot_dn;
            rf_wdata = sum_wrap(rf_rd_b, rf_rd_a);
            top_d    = slot_dn;
            cnt_d    = cnt_q - CW'(1);
            last_ev  = 1'b1;
          end
        end
        OP_POP: begin
          if (cnt_q == '0) begin
            fill_ev  = 1'b1;
            rf_we    = 1'b1;
            rf_waddr = top_q;
            rf_wdata = mem_rdata;
            cnt_d    = CW'(1);
          end else begin
            pop_valid = 1'b1;
            top_d     = slot_dn;
            cnt_d     = cnt_q - CW'(1);
            last_ev   = 1'b1;
          end
        end
        OP_FLUSH: begin
          rf_ra = slot_old;
          if (cnt_q == '0) begin
            last_ev = 1'b1;
          end else begin
            spill_ev = 1'b1;
            cnt_d    = cnt_q - CW'(1);
            last_ev  = (cnt_q == CW'(1));
          end
        end
        default: last_ev = 1'b1;
      endcase
    end
    if (spill_ev) sp_d = sp_q - AW'(1);
    if (fill_ev)  sp_d = sp_q + AW'(1);
  end

  assign mem_req   = spill_ev || fill_ev;
  assign mem_we    = spill_ev;
  assign mem_addr  = spill_ev ? (sp_q - AW'(1)) : sp_q;
  assign mem_wdata = rf_rd_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_PUSH;
      imm_q  <= '0;
      top_q  <= SW'(SLOT_HI);
      cnt_q  <= '0;
      sp_q   <= AW'(SP_RESET);
    end else begin
      top_q <= top_d;
      cnt_q <= cnt_d;
      sp_q  <= sp_d;
      if (accept_ev) begin
        busy_q <= 1'b1;
        op_q   <= stk_op_e'(cmd_op);
        imm_q  <= cmd_imm;
      end else if (last_ev) begin
        busy_q <= 1'b0;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL); // R4
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> !cmd_ready); // R2
  AST_WRITE_LOWERS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> (sp_q == $past(sp_q) - AW'(1))); // R4
  AST_READ_RAISES_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> (sp_q == $past(sp_q) + AW'(1))); // R6
  AST_POP_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> !mem_req); // R5
  AST_ADD_CACHED_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_q == OP_ADD && cnt_q >= CW'(2)) |-> !mem_req); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_q == OP_FLUSH && last_ev) |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/stk_top_cache.sv
module stk_top_cache #(
  parameter int DW       = 16,
  parameter int AW       = 8,
  parameter int SLOT_LO  = 3,
  parameter int SLOT_HI  = 12,
  parameter int SP_RESET = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_imm,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int SW = $clog2(SLOT_HI + 1);

  logic          rf_we;
  logic [SW-1:0] rf_waddr, rf_ra, rf_rb;
  logic [DW-1:0] rf_wdata, rf_rd_a, rf_rd_b;

  stk_ctrl #(
    .DW(DW), .AW(AW), .SLOT_LO(SLOT_LO), .SLOT_HI(SLOT_HI),
    .SW(SW), .SP_RESET(SP_RESET)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_imm(cmd_imm),
    .pop_valid(pop_valid), .pop_data(pop_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_ra(rf_ra), .rf_rb(rf_rb), .rf_rd_a(rf_rd_a), .rf_rd_b(rf_rd_b)
  );

  stk_regring #(
    .DW(DW), .SLOT_LO(SLOT_LO), .SLOT_HI(SLOT_HI), .SW(SW)
  ) u_ring (
    .clk(clk), .wr_en(rf_we), .wr_slot(rf_waddr), .wr_data(rf_wdata),
    .rd_slot_a(rf_ra), .rd_slot_b(rf_rb),
    .rd_data_a(rf_rd_a), .rd_data_b(rf_rd_b)
  );

endmodule

// File: tb/sim_stk_top_cache.sv
`timescale 1ns/1ps
module sim_stk_top_cache;

  localparam int DW = 16, AW = 8, LO = 3, HI = 12, SPR = 200;
  localparam int SIZE = HI - LO + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [DW-1:0] cmd_imm = '0;
  logic pop_valid, mem_req, mem_we;
  logic [DW-1:0] pop_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  always #2 clk = ~clk;

  stk_top_cache #(.DW(DW), .AW(AW), .SLOT_LO(LO), .SLOT_HI(HI), .SP_RESET(SPR)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_imm(cmd_imm), .pop_valid(pop_valid), .pop_data(pop_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [DW-1:0] bmem [0:(1<<AW)-1];
  assign mem_rdata = bmem[mem_addr];

  int n_chk = 0, n_bad = 0;
  int acc = 0, msp = SPR;
  logic [DW-1:0] gstk [0:255];
  int depth = 0, ccnt = 0;
  logic [31:0] lfsr = 32'hACE1_2357;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory model and address monitor (R4 R6 R9)
  always @(posedge clk) begin
    if (rst_n && mem_req) begin
      acc++;
      if (mem_we) begin
        chk(int'(mem_addr) == msp - 1, "R4", "write address", int'(mem_addr), msp - 1);
        bmem[mem_addr] <= mem_wdata;
        msp--;
      end else begin
        chk(int'(mem_addr) == msp, "R6", "read address", int'(mem_addr), msp);
        msp++;
      end
    end
  end

  task automatic do_cmd(input int op, input logic [DW-1:0] imm);
    int exp_cyc, exp_acc, cyc, pops;
    logic [DW-1:0] got, exp_val;
    string tag;
    exp_val = '0;
    case (op)
      0: begin exp_acc = (ccnt == SIZE) ? 1 : 0; exp_cyc = 1; tag = (ccnt == SIZE) ? "R4" : "R3"; end
      1: begin exp_acc = (ccnt >= 2) ? 0 : 2 - ccnt; exp_cyc = exp_acc + 1; tag = (ccnt >= 2) ? "R7" : "R8"; end
      2: begin exp_acc = (ccnt == 0) ? 1 : 0; exp_cyc = exp_acc + 1; tag = (ccnt == 0) ? "R6" : "R5"; end
      default: begin exp_acc = ccnt; exp_cyc = (ccnt == 0) ? 1 : ccnt; tag = (ccnt == 0) ? "R10" : "R9"; end
    endcase
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_imm = imm;
    acc = 0; cyc = 0; pops = 0; got = '0;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) begin
      cyc++;
      if (pop_valid) begin pops++; got = pop_data; end
      if (cyc > 40) break;
      @(negedge clk);
    end
    chk(cyc == exp_cyc, tag, "step count (R2)", cyc, exp_cyc);
    chk(acc == exp_acc, tag, "memory accesses", acc, exp_acc);
    case (op)
      0: begin gstk[depth] = imm; depth++; ccnt = (ccnt == SIZE) ? SIZE : ccnt + 1; end
      1: begin gstk[depth-2] = gstk[depth-2] + gstk[depth-1]; depth--; ccnt = ((ccnt < 2) ? 2 : ccnt) - 1; end
      2: begin exp_val = gstk[depth-1]; depth--; ccnt = (ccnt == 0) ? 0 : ccnt - 1; end
      default: ccnt = 0;
    endcase
    if (op == 2) begin
      chk(pops == 1, "R5", "pop strobes", pops, 1);
      chk(got == exp_val, "R5", "pop value", int'(got), int'(exp_val));
    end else begin
      chk(pops == 0, "R5", "unexpected pop strobe", pops, 0);
    end
    if (op == 3) begin
      for (int i = 0; i < depth; i++)
        chk(bmem[SPR-1-i] == gstk[i], "R9", "memory image", int'(bmem[SPR-1-i]), int'(gstk[i]));
      chk(msp == SPR - depth, "R9", "stack pointer", msp, SPR - depth);
    end
  endtask

  function automatic logic [31:0] step_lfsr(logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
  endfunction

  bit finished = 0;

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) bmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", int'(cmd_ready), 1);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", int'(mem_req), 0);
    chk(pop_valid == 1'b0, "R1", "pop_valid after reset", int'(pop_valid), 0);
    // R3 fill ring, R4 overflow spills first value to SPR-1
    for (int i = 0; i < SIZE + 3; i++) do_cmd(0, DW'(100 + i));
    chk(bmem[SPR-1] == DW'(100), "R1", "first spill at SP_RESET-1", int'(bmem[SPR-1]), 100);
    // R5/R6 drain all, last ones refill
    for (int i = 0; i < SIZE + 3; i++) do_cmd(2, '0);
    // R7 add in ring and modulo wrap
    do_cmd(0, 16'd7); do_cmd(0, 16'd9); do_cmd(1, '0); do_cmd(2, '0);
    do_cmd(0, 16'hFFFF); do_cmd(0, 16'h0003); do_cmd(1, '0); do_cmd(2, '0);
    // R10 empty flush, R9 flush then R8 add from empty and from one
    do_cmd(3, '0);
    for (int i = 0; i < 5; i++) do_cmd(0, DW'(40 + i));
    do_cmd(3, '0); do_cmd(3, '0);
    do_cmd(1, '0);
    do_cmd(3, '0); do_cmd(0, 16'd5); do_cmd(1, '0);
    while (depth > 0) do_cmd(2, '0);
    // mixed sweep
    for (int n = 0; n < 4000; n++) begin
      int sel, op;
      lfsr = step_lfsr(lfsr);
      sel = int'(lfsr[2:0]);
      op = (sel <= 2 || sel == 7) ? 0 : (sel <= 4) ? 1 : (sel == 5) ? 2 : 3;
      if (op == 1 && depth < 2) op = 0;
      if (op == 2 && depth < 1) op = 0;
      if (op == 0 && depth >= 60) op = 2;
      do_cmd(op, lfsr[31:16]);
    end
    do_cmd(3, '0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule